// File: doc/BRIEF.md
# Sliced Vertical-Blanking Data Record FIFO

This block buffers sliced vertical-blanking data between a line slicer and a host register interface. Data enters as whole line records: a header followed by the payload. The producer first issues a start request that carries the record's total length in bytes. Each byte of the record then follows on its own cycle. The FIFO compares that length with the free space at the moment of the request. It then either reserves room for the complete record or throws the whole record away. A partial line therefore never reaches the host.

The host side is a single byte-read strobe with a registered data output. The block reports whether it is empty, keeps a sticky overflow flag, and gives the fill level in 16-bit words. The word count comes both at full width and clipped to eight bits. An interrupt request rises when the word count passes a programmable threshold. A flush strobe, meant to be driven by a write of any value to a reset register, discards everything stored.

Top module: `vbi_rec_fifo`

## Requirements
- R1: After reset, `empty` is 1, `word_cnt` and `word_cnt_sat` are 0, `full_err` is 0, and the threshold is 0x80. `irq` is 0 whatever `irq_en` is.
- R2: A start request with nonzero `rec_len` no larger than the free space (DEPTH minus stored bytes) opens a record. The next `rec_len` bytes presented with `wr_valid` are all stored, and reads return every stored byte in arrival order. The stored byte count never exceeds DEPTH.
- R3: A start request whose `rec_len` exceeds the free space stores none of that record's bytes and sets `full_err`.
- R4: A later record that fits the remaining space is stored even while `full_err` is 1.
- R5: `full_err` stays 1 until a cycle with `err_clr` high. When an overflow and `err_clr` fall in the same cycle, the flag is left set.
- R6: A start request with `rec_bad`=1 and `rec_drop_bad`=1 is discarded without touching `full_err`. With `rec_bad`=1 and `rec_drop_bad`=0, the record is stored normally.
- R7: `word_cnt` equals the stored byte count divided by 2, rounded down. It is 9 bits wide, so a full 512-byte FIFO reads 256. `word_cnt_sat` equals `word_cnt` clipped to 255.
- R8: `irq` is 1 exactly when `irq_en` is 1 and `word_cnt` is greater than the threshold. A cycle with `thr_we` high loads `thr_din` into the threshold.
- R9: A `flush` cycle empties the FIFO and abandons any open record, so the rest of that record's bytes are ignored. `full_err` and the threshold keep their values.
- R10: A read strobe on an empty FIFO sets `rd_data` to 0x00 and leaves the read order unchanged. Any read result appears on `rd_data` one cycle after the strobe.
- R11: A read and a stored write in the same cycle both take effect: the oldest byte is returned and the byte count is unchanged.
- R12: A start request made while a record is open is ignored. Bytes presented while no record is open are ignored. A start request with `rec_len`=0 has no effect.
- R13: `empty` is 1 exactly when no byte is stored, which includes a single stored byte giving `word_cnt`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_start | input | 1 | Start request for a new record |
| rec_len | input | 10 | Total record length in bytes, header included |
| rec_bad | input | 1 | Record carries detected errors |
| rec_drop_bad | input | 1 | Line option: discard records that carry errors |
| wr_valid | input | 1 | Record byte present on `wr_byte` |
| wr_byte | input | 8 | Record byte |
| rd_req | input | 1 | Host byte-read strobe |
| rd_data | output | 8 | Byte returned by the last read strobe |
| flush | input | 1 | Discard all contents (any-value write to reset register) |
| err_clr | input | 1 | Write-1 clear of `full_err` |
| thr_we | input | 1 | Load interrupt threshold |
| thr_din | input | 8 | New threshold in words |
| irq_en | input | 1 | Threshold interrupt enable |
| empty | output | 1 | No byte stored |
| full_err | output | 1 | Sticky flag: a record was refused for lack of space |
| word_cnt | output | 9 | Stored 16-bit words |
| word_cnt_sat | output | 8 | Word count clipped to 255 |
| irq | output | 1 | Threshold interrupt request |

## Verification
The main function is driven with a sequence of records of varied length and flags, and the FIFO is never drained along the way. An error-flagged record that is kept is separated from one that is rejected. A record that overflows is separated from a smaller record that follows it and still fits. Exact fill to 512 bytes shows the 256-word count and its clipped form. Draining all 512 bytes and comparing them to a model shows whether any byte of a dropped record leaked into the stream. Further directed patterns cover a start request inside an open record, a read overlapping a write, a read from empty, a flush in the middle of a record, and the threshold compared at equality and one word above it.

// File: rtl/vbi_rec_fifo.sv
module vbi_rec_fifo #(
  parameter int DEPTH = 512,
  parameter int DW = 8,
  parameter int THR_W = 8,
  parameter logic [THR_W-1:0] THR_RST = 8'h80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rec_start,
  input  logic [$clog2(DEPTH):0] rec_len,
  input  logic             rec_bad,
  input  logic             rec_drop_bad,
  input  logic             wr_valid,
  input  logic [DW-1:0]    wr_byte,
  input  logic             rd_req,
  output logic [DW-1:0]    rd_data,
  input  logic             flush,
  input  logic             err_clr,
  input  logic             thr_we,
  input  logic [THR_W-1:0] thr_din,
  input  logic             irq_en,
  output logic             empty,
  output logic             full_err,
  output logic [$clog2(DEPTH)-1:0] word_cnt,
  output logic [THR_W-1:0] word_cnt_sat,
  output logic             irq
);
  localparam int AW  = $clog2(DEPTH);
  localparam int CW  = AW + 1;
  localparam int WCW = AW;

  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    cnt, left, free_b;
  logic [THR_W-1:0] thr;
  logic             open_rec, try_start, bad_drop, fits, admit, overflow, do_wr, do_rd;

  assign open_rec  = left != '0;
  assign free_b    = CW'(DEPTH) - cnt;
  assign try_start = rec_start && !open_rec && (rec_len != '0) && !flush;
  assign bad_drop  = rec_bad && rec_drop_bad;
  assign fits      = rec_len <= free_b;
  assign admit     = try_start && !bad_drop && fits;
  assign overflow  = try_start && !bad_drop && !fits;
  assign do_wr     = wr_valid && open_rec && !flush;
  assign do_rd     = rd_req && (cnt != '0) && !flush;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      cnt     <= '0;
      left    <= '0;
      rd_data <= '0;
    end else if (flush) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      left <= '0;
    end else begin
      if (do_wr) wptr <= wptr + AW'(1);
      if (do_rd) begin
        rptr    <= rptr + AW'(1);
        rd_data <= mem[rptr];
      end else if (rd_req) begin
        rd_data <= '0;
      end
      cnt <= cnt + CW'(do_wr) - CW'(do_rd);
      if (admit)      left <= rec_len;
      else if (do_wr) left <= left - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        full_err <= 1'b0;
    else if (overflow) full_err <= 1'b1;
    else if (err_clr)  full_err <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      thr <= THR_RST;
    else if (thr_we) thr <= thr_din;
  end

  assign empty        = cnt == '0;
  assign word_cnt     = cnt[CW-1:1];
  assign word_cnt_sat = (word_cnt > WCW'({THR_W{1'b1}})) ? {THR_W{1'b1}} : word_cnt[THR_W-1:0];
  assign irq          = irq_en && (word_cnt > WCW'(thr));
endmodule

module vbi_rec_fifo_chk #(
  parameter int DEPTH = 512,
  parameter int DW = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    rec_start,
  input logic                    rec_bad,
  input logic                    rec_drop_bad,
  input logic                    wr_valid,
  input logic                    rd_req,
  input logic [DW-1:0]           rd_data,
  input logic                    flush,
  input logic                    err_clr,
  input logic                    irq_en,
  input logic                    empty,
  input logic                    full_err,
  input logic                    irq,
  input logic                    rec_open,
  input logic [$clog2(DEPTH):0]  cnt
);
  localparam int CW = $clog2(DEPTH) + 1;

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (full_err && !err_clr) |=> full_err);

  assert_bad_drop_no_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_start && !rec_open && rec_bad && rec_drop_bad && !err_clr && !flush)
      |=> (full_err == $past(full_err)));

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty && !rec_open));

  assert_empty_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && empty && !flush) |=> (rd_data == '0));

  assert_idle_count_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !rd_req && !wr_valid) |=> $stable(cnt));
endmodule

bind vbi_rec_fifo vbi_rec_fifo_chk #(.DEPTH(DEPTH), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .rec_start(rec_start), .rec_bad(rec_bad),
  .rec_drop_bad(rec_drop_bad), .wr_valid(wr_valid), .rd_req(rd_req),
  .rd_data(rd_data), .flush(flush), .err_clr(err_clr), .irq_en(irq_en),
  .empty(empty), .full_err(full_err), .irq(irq), .rec_open(open_rec), .cnt(cnt)
);

// File: tb/vbi_rec_fifo_tb.sv
module vbi_rec_fifo_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, rec_start, rec_bad, rec_drop_bad, wr_valid, rd_req;
  logic       flush, err_clr, thr_we, irq_en;
  logic [9:0] rec_len;
  logic [7:0] wr_byte, thr_din, rd_data, word_cnt_sat;
  logic       empty, full_err, irq;
  logic [8:0] word_cnt;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [7:0] seq = 8'd0;
  logic [7:0] mq[$];

  always #10 clk = ~clk;

  vbi_rec_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .rec_start(rec_start), .rec_len(rec_len),
    .rec_bad(rec_bad), .rec_drop_bad(rec_drop_bad), .wr_valid(wr_valid),
    .wr_byte(wr_byte), .rd_req(rd_req), .rd_data(rd_data), .flush(flush),
    .err_clr(err_clr), .thr_we(thr_we), .thr_din(thr_din), .irq_en(irq_en),
    .empty(empty), .full_err(full_err), .word_cnt(word_cnt),
    .word_cnt_sat(word_cnt_sat), .irq(irq)
  );

  function automatic logic [15:0] mkv(int len, bit bad, bit rej, bit acc, bit err);
    logic [9:0] l = 10'(len);
    return {bad, rej, acc, err, 2'b00, l};
  endfunction

  // {bad, drop_bad, expect_stored, expect_full_err, 2'b0, length}
  localparam logic [15:0] VEC [9] = '{
    mkv(40, 0, 0, 1, 0), mkv(100, 1, 0, 1, 0), mkv(30, 1, 1, 0, 0),
    mkv(300, 0, 0, 1, 0), mkv(100, 0, 0, 0, 1), mkv(6, 0, 0, 1, 1),
    mkv(0, 0, 0, 0, 1), mkv(66, 0, 0, 1, 1), mkv(1, 0, 0, 0, 1)
  };

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_rec(int len, bit bad, bit rej, bit keep);
    rec_start = 1; rec_len = 10'(len); rec_bad = bad; rec_drop_bad = rej;
    @(negedge clk);
    rec_start = 0; rec_bad = 0; rec_drop_bad = 0;
    for (int i = 0; i < len; i++) begin
      wr_valid = 1; wr_byte = seq ^ 8'h5A; seq++;
      if (keep) mq.push_back(wr_byte);
      @(negedge clk);
    end
    wr_valid = 0;
  endtask

  task automatic rd1(output logic [7:0] b);
    rd_req = 1;
    @(negedge clk);
    rd_req = 0;
    b = rd_data;
  endtask

  task automatic drain(string req, int n);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      rd1(b);
      chk(req, b, mq.pop_front());
    end
  endtask

  task automatic do_flush();
    flush = 1;
    @(negedge clk);
    flush = 0;
    mq.delete();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int bytes;
    logic [7:0] b;
    rst_n = 0; rec_start = 0; rec_len = 0; rec_bad = 0; rec_drop_bad = 0;
    wr_valid = 0; wr_byte = 0; rd_req = 0; flush = 0; err_clr = 0;
    thr_we = 0; thr_din = 0; irq_en = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state, irq_en already 1 with threshold 0x80
    chk("R1 empty", empty, 1);
    chk("R1 word_cnt", word_cnt, 0);
    chk("R1 word_cnt_sat", word_cnt_sat, 0);
    chk("R1 full_err", full_err, 0);
    chk("R1 irq", irq, 0);

    // Vector table walk: no reads in between
    bytes = 0;
    for (int v = 0; v < 9; v++) begin
      send_rec(int'(VEC[v][9:0]), VEC[v][15], VEC[v][14], VEC[v][13]);
      if (VEC[v][13]) bytes += int'(VEC[v][9:0]);
      chk("R2 R3 R4 R6 R12 word_cnt", word_cnt, bytes / 2);
      chk("R7 word_cnt_sat", word_cnt_sat, (bytes / 2 > 255) ? 255 : bytes / 2);
      chk("R3 R5 R6 full_err", full_err, VEC[v][12]);
      chk("R8 irq default threshold", irq, (bytes / 2 > 128) ? 1 : 0);
      chk("R13 empty", empty, (bytes == 0) ? 1 : 0);
    end
    chk("R7 full word count", word_cnt, 256);

    // R5: sticky, then cleared by err_clr
    @(negedge clk);
    chk("R5 sticky", full_err, 1);
    err_clr = 1; @(negedge clk); err_clr = 0;
    chk("R5 cleared", full_err, 0);

    // R2/R3/R4: full drain checks order and that dropped bytes never entered
    drain("R2 data order", 512);
    chk("R13 empty after drain", empty, 1);
    chk("R7 count after drain", word_cnt, 0);

    // R10: read from empty gives zero, order unchanged
    rd1(b);
    chk("R10 empty read data", b, 0);
    chk("R10 empty read count", word_cnt, 0);
    send_rec(2, 0, 0, 1);
    drain("R10 order after empty read", 2);

    // R12: start during open record ignored, stray byte ignored
    rec_start = 1; rec_len = 10'd4; @(negedge clk); rec_start = 0;
    wr_valid = 1; wr_byte = 8'hA1; mq.push_back(wr_byte); @(negedge clk);
    rec_start = 1; rec_len = 10'd600;
    wr_byte = 8'hA2; mq.push_back(wr_byte); @(negedge clk);
    rec_start = 0;
    wr_byte = 8'hA3; mq.push_back(wr_byte); @(negedge clk);
    wr_byte = 8'hA4; mq.push_back(wr_byte); @(negedge clk);
    wr_byte = 8'hEE; @(negedge clk);
    wr_valid = 0;
    chk("R12 start ignored no full_err", full_err, 0);
    chk("R12 stray byte ignored", word_cnt, 2);
    drain("R12 record data", 4);

    // R11: simultaneous read and write
    send_rec(4, 0, 0, 1);
    rec_start = 1; rec_len = 10'd3; @(negedge clk); rec_start = 0;
    for (int i = 0; i < 3; i++) begin
      wr_valid = 1; wr_byte = 8'hC0 + 8'(i); mq.push_back(wr_byte);
      rd_req = 1;
      @(negedge clk);
      chk("R11 read during write", rd_data, mq.pop_front());
    end
    wr_valid = 0; rd_req = 0;
    chk("R11 count unchanged", word_cnt, 2);
    drain("R11 remaining data", 4);

    // R10/R11: read from empty while a byte is written
    rec_start = 1; rec_len = 10'd1; @(negedge clk); rec_start = 0;
    wr_valid = 1; wr_byte = 8'h77; rd_req = 1; @(negedge clk);
    wr_valid = 0; rd_req = 0;
    chk("R10 empty read with write", rd_data, 0);
    chk("R13 single byte not empty", empty, 0);
    chk("R13 single byte word_cnt", word_cnt, 0);
    rd1(b);
    chk("R11 written byte kept", b, 8'h77);

    // R9: flush mid-record, full_err and threshold kept
    send_rec(10, 0, 0, 1);
    send_rec(600, 0, 0, 0);
    chk("R3 oversize sets full_err", full_err, 1);
    rec_start = 1; rec_len = 10'd5; @(negedge clk); rec_start = 0;
    wr_valid = 1; wr_byte = 8'h11; @(negedge clk);
    wr_byte = 8'h12; @(negedge clk);
    wr_valid = 0;
    do_flush();
    chk("R9 flush empties", empty, 1);
    chk("R9 full_err kept", full_err, 1);
    wr_valid = 1;
    for (int i = 0; i < 3; i++) begin wr_byte = 8'h13; @(negedge clk); end
    wr_valid = 0;
    chk("R9 open record abandoned", empty, 1);
    send_rec(3, 0, 0, 1);
    drain("R9 new data after flush", 3);
    err_clr = 1; @(negedge clk); err_clr = 0;

    // R8: programmed threshold, equality and above, enable gating
    thr_we = 1; thr_din = 8'd3; @(negedge clk); thr_we = 0;
    send_rec(6, 0, 0, 1);
    chk("R8 irq at equality", irq, 0);
    send_rec(2, 0, 0, 1);
    chk("R8 irq above threshold", irq, 1);
    irq_en = 0; @(negedge clk);
    chk("R8 irq gated", irq, 0);
    irq_en = 1;
    do_flush();
    chk("R9 threshold kept", irq, 0);
    send_rec(8, 0, 0, 1);
    chk("R9 threshold kept after flush", irq, 1);

    finish_run();
  end
endmodule